// File: doc/BRIEF.md
# Decode-Stage Direct Branch Checker

This block sits in the decode stage and looks at a group of up to `W` instructions per cycle, in program order, lane 0 being the oldest. Each lane carries a sequence number, its PC, its actual next PC, the next PC that fetch predicted, a target computed earlier in decode, a predicted-taken bit and class flags. For every direct, unconditional control instruction it compares the computed target with the prediction. When they differ it sends a redirect to fetch and withholds every younger lane from the downstream stage. The squash boundary is expressed as a sequence number.

The redirect is combinational in the cycle the mismatch is seen. When the `DS` parameter is set, the block supports architectures with a branch delay slot. A mismatching branch that was predicted taken and whose delay slot is conditional squashes at its own sequence number. Any other mismatching branch lets its delay-slot instruction through first. If that instruction is not in the same group, one pending entry holds the redirect until the next cycle that carries a valid instruction. Instruction size is the `ISZ` parameter.

Top module: `branch_check_unit`

## Requirements
- R1: A lane is checked only when it is valid with ctrl, direct and uncond all 1. Indirect or conditional lanes never cause a redirect. `resolved_cnt` counts forwarded checked lanes, and is 0 in a cycle where a pending redirect fires.
- R2: A checked lane mismatches when its target differs from its predicted next PC. A group with no mismatch raises no redirect and forwards every valid lane.
- R3: On a redirect, `redir_npc` is the target, `redir_nnpc` is the target plus `ISZ`, and `redir_seq` is the branch's sequence number.
- R4: `redir_taken` is 1 exactly when the branch's actual next PC differs from its PC plus `ISZ`.
- R5: While a redirect is raised, no lane whose sequence number exceeds `redir_squash_seq` is forwarded. The mismatching lane's `out_pred_npc` is replaced by its target; other lanes pass their prediction unchanged.
- R6: At most one redirect is raised per cycle, and it comes from the lowest-numbered (oldest) mismatching lane.
- R7: With `DS`=0, `redir_squash_seq` equals `redir_seq`, so only lanes up to and including the branch are forwarded.
- R8: With `DS`=1, a mismatching branch whose predicted-taken bit and conditional-delay-slot bit are both 1 redirects at once, with `redir_squash_seq` equal to its own sequence number.
- R9: With `DS`=1, any other mismatching branch uses `redir_squash_seq` equal to its sequence number plus 1. When the next lane is valid, the redirect is raised in the same cycle and that lane is forwarded.
- R10: With `DS`=1, if such a branch is the last valid lane, no redirect is raised that cycle. The redirect, with the saved target, taken bit and sequence number, is raised in the next cycle that has a valid lane. Only that cycle's lane with sequence number branch+1 is forwarded, and no lane is checked in that cycle.
- R11: `ctrl_mis` flags each forwarded lane that is predicted taken but is not a control instruction.
- R12: Reset clears a pending delayed redirect. After reset, a plain group raises no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | W | Lane valid, packed from lane 0 |
| in_seq | input | W*SW | Lane sequence numbers |
| in_pc | input | W*AW | Lane PCs |
| in_npc | input | W*AW | Lane actual next PCs |
| in_pred_npc | input | W*AW | Lane predicted next PCs |
| in_target | input | W*AW | Lane computed branch targets |
| in_pred_taken | input | W | Lane predicted-taken bits |
| in_ctrl | input | W | Lane is a control instruction |
| in_direct | input | W | Lane is a direct control instruction |
| in_uncond | input | W | Lane is an unconditional control instruction |
| in_cond_ds | input | W | Lane's delay slot is conditional |
| out_valid | output | W | Lane forwarded downstream |
| out_pred_npc | output | W*AW | Lane prediction, corrected on mismatch |
| ctrl_mis | output | W | Lane predicted taken but not control |
| resolved_cnt | output | $clog2(W+1) | Forwarded checked lanes this cycle |
| redir_valid | output | 1 | Redirect and squash raised |
| redir_npc | output | AW | Redirect next PC |
| redir_nnpc | output | AW | Redirect next-next PC |
| redir_taken | output | 1 | Branch was actually taken |
| redir_seq | output | SW | Sequence number of the branch |
| redir_squash_seq | output | SW | Lanes with larger sequence numbers are squashed |

## Verification
The assertions rely on three assumptions about the inputs. Valid lanes are packed from lane 0. Sequence numbers rise by one per lane in program order. A delay-slot instruction carries its branch's sequence number plus one, and no sequence number wraps within a test. The stimulus builds every group from a base number plus the lane index, keeps lanes contiguous, and resumes after a held branch with base equal to the branch's number plus one. Under these conditions the squash boundary checks and the pending-fire check describe only legal traffic.

// File: rtl/branch_check_unit.sv
module branch_check_unit #(
  parameter int W   = 4,
  parameter int SW  = 16,
  parameter int AW  = 32,
  parameter int ISZ = 4,
  parameter int DS  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             in_valid,
  input  logic [W*SW-1:0]          in_seq,
  input  logic [W*AW-1:0]          in_pc,
  input  logic [W*AW-1:0]          in_npc,
  input  logic [W*AW-1:0]          in_pred_npc,
  input  logic [W*AW-1:0]          in_target,
  input  logic [W-1:0]             in_pred_taken,
  input  logic [W-1:0]             in_ctrl,
  input  logic [W-1:0]             in_direct,
  input  logic [W-1:0]             in_uncond,
  input  logic [W-1:0]             in_cond_ds,
  output logic [W-1:0]             out_valid,
  output logic [W*AW-1:0]          out_pred_npc,
  output logic [W-1:0]             ctrl_mis,
  output logic [$clog2(W+1)-1:0]   resolved_cnt,
  output logic                     redir_valid,
  output logic [AW-1:0]            redir_npc,
  output logic [AW-1:0]            redir_nnpc,
  output logic                     redir_taken,
  output logic [SW-1:0]            redir_seq,
  output logic [SW-1:0]            redir_squash_seq
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = $clog2(W + 1);
  localparam logic [AW-1:0] STEP = AW'(ISZ);

  logic [SW-1:0] seq  [W];
  logic [AW-1:0] pc   [W];
  logic [AW-1:0] npc  [W];
  logic [AW-1:0] pnpc [W];
  logic [AW-1:0] tgt  [W];
  logic [W-1:0]  chk;
  logic [W-1:0]  mis;
  logic [W-1:0]  kill;

  logic          pend;
  logic [SW-1:0] p_seq;
  logic [AW-1:0] p_tgt;
  logic          p_tkn;

  logic          hit;
  logic [IW-1:0] hidx;
  logic          nxt_v;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_lane
      assign seq[g]  = in_seq[g*SW +: SW];
      assign pc[g]   = in_pc[g*AW +: AW];
      assign npc[g]  = in_npc[g*AW +: AW];
      assign pnpc[g] = in_pred_npc[g*AW +: AW];
      assign tgt[g]  = in_target[g*AW +: AW];
      assign chk[g]  = in_valid[g] & in_ctrl[g] & in_direct[g] & in_uncond[g];
      assign mis[g]  = chk[g] & ~pend & (tgt[g] != pnpc[g]);
      assign kill[g] = redir_valid & (seq[g] > redir_squash_seq);
      assign out_valid[g] = in_valid[g] & ~kill[g];
      assign ctrl_mis[g]  = out_valid[g] & in_pred_taken[g] & ~in_ctrl[g];
      assign out_pred_npc[g*AW +: AW] = (hit && hidx == IW'(g)) ? tgt[g] : pnpc[g];
    end
  endgenerate

  always_comb begin
    hit   = 1'b0;
    hidx  = '0;
    nxt_v = 1'b0;
    for (int j = 0; j < W; j++) begin
      if (!hit && mis[j]) begin
        hit   = 1'b1;
        hidx  = IW'(j);
        nxt_v = (j + 1 < W) ? in_valid[(j + 1) % W] : 1'b0;
      end
    end
  end

  logic immed, defer, now_ds, go_pend, pend_fire;
  assign immed     = hit & ((DS == 0) | (in_pred_taken[hidx] & in_cond_ds[hidx]));
  assign defer     = hit & ~immed;
  assign now_ds    = defer & nxt_v;
  assign go_pend   = defer & ~nxt_v;
  assign pend_fire = pend & (|in_valid);

  logic [AW-1:0] h_tgt;
  logic          h_tkn;
  assign h_tgt = tgt[hidx];
  assign h_tkn = npc[hidx] != (pc[hidx] + STEP);

  assign redir_valid      = immed | now_ds | pend_fire;
  assign redir_npc        = pend ? p_tgt : h_tgt;
  assign redir_nnpc       = redir_npc + STEP;
  assign redir_taken      = pend ? p_tkn : h_tkn;
  assign redir_seq        = pend ? p_seq : seq[hidx];
  assign redir_squash_seq = pend  ? p_seq + SW'(1) :
                            immed ? seq[hidx] : seq[hidx] + SW'(1);

  always_comb begin
    resolved_cnt = '0;
    for (int j = 0; j < W; j++)
      if (out_valid[j] && chk[j] && !pend) resolved_cnt = resolved_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      p_seq <= '0;
      p_tgt <= '0;
      p_tkn <= 1'b0;
    end else if (pend) begin
      if (|in_valid) pend <= 1'b0;
    end else if (go_pend) begin
      pend  <= 1'b1;
      p_seq <= seq[hidx];
      p_tgt <= h_tgt;
      p_tkn <= h_tkn;
    end
  end
endmodule

module branch_check_chk #(
  parameter int W   = 4,
  parameter int SW  = 16,
  parameter int AW  = 32,
  parameter int ISZ = 4,
  parameter int DS  = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [W-1:0]           in_valid,
  input logic [W*SW-1:0]        in_seq,
  input logic [W-1:0]           out_valid,
  input logic [$clog2(W+1)-1:0] resolved_cnt,
  input logic                   redir_valid,
  input logic [AW-1:0]          redir_npc,
  input logic [AW-1:0]          redir_nnpc,
  input logic [SW-1:0]          redir_seq,
  input logic [SW-1:0]          redir_squash_seq,
  input logic                   pend
);
  // R3
  nnpc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_nnpc == redir_npc + AW'(ISZ));

  // R5
  fwd_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & ~in_valid) == '0);

  // R1
  resolved_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(resolved_cnt) <= $countones(out_valid));

  // R7
  squash_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_squash_seq == redir_seq) ||
                    (DS != 0 && redir_squash_seq == redir_seq + SW'(1)));

  // R10
  pend_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && |in_valid) |-> redir_valid);

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(|in_valid)) |=> pend);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_young
      // R5
      no_young_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !(out_valid[g] && in_seq[g*SW +: SW] > redir_squash_seq));
    end
  endgenerate
endmodule

bind branch_check_unit branch_check_chk #(.W(W), .SW(SW), .AW(AW), .ISZ(ISZ), .DS(DS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq),
  .out_valid(out_valid), .resolved_cnt(resolved_cnt), .redir_valid(redir_valid),
  .redir_npc(redir_npc), .redir_nnpc(redir_nnpc), .redir_seq(redir_seq),
  .redir_squash_seq(redir_squash_seq), .pend(pend));

// File: tb/branch_check_unit_test.sv
module branch_check_unit_test;
  localparam int W = 4, SW = 16, AW = 32;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [W-1:0] v, pt, ct, dr, un, cd;
  logic [SW-1:0] s_seq [W];
  logic [AW-1:0] s_pc [W], s_npc [W], s_pn [W], s_tg [W];
  logic [W*SW-1:0] f_seq;
  logic [W*AW-1:0] f_pc, f_npc, f_pn, f_tg;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pack
      assign f_seq[g*SW +: SW] = s_seq[g];
      assign f_pc[g*AW +: AW]  = s_pc[g];
      assign f_npc[g*AW +: AW] = s_npc[g];
      assign f_pn[g*AW +: AW]  = s_pn[g];
      assign f_tg[g*AW +: AW]  = s_tg[g];
    end
  endgenerate

  logic [W-1:0] ov, cm, d_ov, d_cm;
  logic [W*AW-1:0] opn, d_opn;
  logic [2:0] rc, d_rc;
  logic rv, rt, d_rv, d_rt;
  logic [AW-1:0] rn, rnn, d_rn, d_rnn;
  logic [SW-1:0] rs, rq, d_rs, d_rq;

  branch_check_unit #(.W(W), .SW(SW), .AW(AW), .ISZ(4), .DS(0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_seq(f_seq), .in_pc(f_pc), .in_npc(f_npc),
    .in_pred_npc(f_pn), .in_target(f_tg), .in_pred_taken(pt), .in_ctrl(ct), .in_direct(dr),
    .in_uncond(un), .in_cond_ds(cd), .out_valid(ov), .out_pred_npc(opn), .ctrl_mis(cm),
    .resolved_cnt(rc), .redir_valid(rv), .redir_npc(rn), .redir_nnpc(rnn), .redir_taken(rt),
    .redir_seq(rs), .redir_squash_seq(rq));

  branch_check_unit #(.W(W), .SW(SW), .AW(AW), .ISZ(4), .DS(1)) uut_ds (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_seq(f_seq), .in_pc(f_pc), .in_npc(f_npc),
    .in_pred_npc(f_pn), .in_target(f_tg), .in_pred_taken(pt), .in_ctrl(ct), .in_direct(dr),
    .in_uncond(un), .in_cond_ds(cd), .out_valid(d_ov), .out_pred_npc(d_opn), .ctrl_mis(d_cm),
    .resolved_cnt(d_rc), .redir_valid(d_rv), .redir_npc(d_rn), .redir_nnpc(d_rnn),
    .redir_taken(d_rt), .redir_seq(d_rs), .redir_squash_seq(d_rq));

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic grp(input int base, input int nv);
    for (int j = 0; j < W; j++) begin
      v[j] = (j < nv); pt[j] = 0; ct[j] = 0; dr[j] = 0; un[j] = 0; cd[j] = 0;
      s_seq[j] = SW'(base + j);
      s_pc[j] = 32'h100 + 32'(4 * j);
      s_npc[j] = s_pc[j] + 4; s_pn[j] = s_pc[j] + 4; s_tg[j] = 0;
    end
  endtask

  task automatic br(input int j, input bit mis, input bit p_t, input bit c_d);
    ct[j] = 1; dr[j] = 1; un[j] = 1; pt[j] = p_t; cd[j] = c_d;
    s_tg[j] = 32'h800; s_npc[j] = 32'h800;
    s_pn[j] = mis ? 32'h900 : 32'h800;
  endtask

  // {bidx[1:0], mis, nvalid[2:0], exp_redir, 0, exp_mask[3:0]}
  localparam logic [11:0] VEC [6] = '{
    12'b00_0_100_0_0_1111,
    12'b00_1_100_1_0_0001,
    12'b10_1_100_1_0_0111,
    12'b11_1_100_1_0_1111,
    12'b01_1_010_1_0_0011,
    12'b01_0_011_0_0_0111
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    grp(0, 0);
    repeat (2) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12 reset redir", {63'd0, rv}, 0);
    chk("R12 reset out_valid", {60'd0, ov}, 0);
    @(negedge clk); rst_n = 1;

    // table: R2 R3 R5 R7
    for (int k = 0; k < 6; k++) begin
      logic [11:0] e;
      int bi;
      e = VEC[k]; bi = int'(e[11:10]);
      @(negedge clk);
      grp(10 * k + 10, int'(e[8:6]));
      br(bi, e[9], 0, 0);
      #1;
      chk("R2 redir", {63'd0, rv}, {63'd0, e[5]});
      chk("R7 fwd mask", {60'd0, ov}, {60'd0, e[3:0]});
      chk("R1 resolved", {61'd0, rc}, 1);
      if (e[5]) begin
        chk("R3 npc", {32'd0, rn}, 32'h800);
        chk("R3 nnpc", {32'd0, rnn}, 32'h804);
        chk("R3 seq", {48'd0, rs}, 64'(10 * k + 10 + bi));
        chk("R7 squash seq", {48'd0, rq}, 64'(10 * k + 10 + bi));
        chk("R4 taken", {63'd0, rt}, 1);
        chk("R5 corrected pred", {32'd0, opn[bi*AW +: AW]}, 32'h800);
      end
    end

    // R4 not taken
    @(negedge clk); grp(100, 4); br(0, 1, 0, 0); s_npc[0] = 32'h104; #1;
    chk("R4 taken clear", {63'd0, rt}, 0);

    // R6 oldest wins
    @(negedge clk); grp(110, 4); br(1, 1, 0, 0); br(2, 1, 0, 0); s_tg[2] = 32'h700; #1;
    chk("R6 seq", {48'd0, rs}, 111);
    chk("R6 mask", {60'd0, ov}, 4'b0011);
    chk("R5 other lane pred", {32'd0, opn[0 +: AW]}, 32'h104);

    // R1 indirect and conditional mismatches ignored
    @(negedge clk); grp(120, 4); br(1, 1, 0, 0); dr[1] = 0; br(2, 1, 0, 0); un[2] = 0; #1;
    chk("R1 no redir", {63'd0, rv}, 0);
    chk("R1 resolved zero", {61'd0, rc}, 0);
    chk("R1 mask", {60'd0, ov}, 4'b1111);

    // R1 count two matching branches
    @(negedge clk); grp(130, 4); br(1, 0, 0, 0); br(3, 0, 0, 0); #1;
    chk("R1 resolved two", {61'd0, rc}, 2);

    // R11
    @(negedge clk); grp(140, 4); pt[2] = 1; #1;
    chk("R11 ctrl mis", {60'd0, cm}, 4'b0100);
    @(negedge clk); grp(150, 4); br(0, 1, 0, 0); pt[2] = 1; #1;
    chk("R11 killed lane not flagged", {60'd0, cm}, 0);

    // R8 DS immediate
    @(negedge clk); rst_n = 0; grp(0, 0); @(negedge clk); rst_n = 1;
    grp(40, 4); br(0, 1, 1, 1); #1;
    chk("R8 redir", {63'd0, d_rv}, 1);
    chk("R8 squash seq", {48'd0, d_rq}, 40);
    chk("R8 mask", {60'd0, d_ov}, 4'b0001);

    // R9 DS in group
    @(negedge clk); grp(40, 4); br(1, 1, 0, 0); #1;
    chk("R9 redir", {63'd0, d_rv}, 1);
    chk("R9 squash seq", {48'd0, d_rq}, 42);
    chk("R9 seq", {48'd0, d_rs}, 41);
    chk("R9 mask", {60'd0, d_ov}, 4'b0111);

    // R10 DS across cycles
    @(negedge clk); grp(50, 2); br(1, 1, 0, 0); #1;
    chk("R10 held", {63'd0, d_rv}, 0);
    chk("R10 mask", {60'd0, d_ov}, 4'b0011);
    @(negedge clk); grp(52, 0); #1;
    chk("R10 wait empty", {63'd0, d_rv}, 0);
    @(negedge clk); grp(52, 3); br(1, 1, 0, 0); #1;
    chk("R10 fire", {63'd0, d_rv}, 1);
    chk("R10 seq", {48'd0, d_rs}, 51);
    chk("R10 squash seq", {48'd0, d_rq}, 52);
    chk("R10 npc", {32'd0, d_rn}, 32'h800);
    chk("R10 taken", {63'd0, d_rt}, 1);
    chk("R10 mask", {60'd0, d_ov}, 4'b0001);
    chk("R10 no checks", {61'd0, d_rc}, 0);
    @(negedge clk); grp(60, 4); #1;
    chk("R10 cleared", {63'd0, d_rv}, 0);

    // R12 reset drops pending
    @(negedge clk); grp(70, 1); br(0, 1, 0, 0); #1;
    chk("R12 pend setup", {63'd0, d_rv}, 0);
    @(negedge clk); rst_n = 0; grp(0, 0);
    @(negedge clk); rst_n = 1; grp(71, 4); #1;
    chk("R12 no redir after reset", {63'd0, d_rv}, 0);
    chk("R12 mask", {60'd0, d_ov}, 4'b1111);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule